// File: doc/BRIEF.md
# GPIO Port With Per-Pin Interrupt Detection

This block is a single general-purpose I/O channel of up to sixteen pins, controlled through a simple 32-bit register bus. Each pin can be set to drive or to receive. It has an output latch, and its input passes through a two-flop synchronizer before it can be read. Software writes a word address with `wr_en` or reads one with `rd_en`. Read data appears on `rdata` one cycle after the read strobe.

Each pin has its own event detector. The detector can be set to trigger on a falling edge, a rising edge, both edges, a low level or a high level. A pin records an event only while its enable bit is set. An event sets a sticky status bit, and software clears that bit by writing a one to it. A per-pin mask is set and cleared through two separate write-one registers. The interrupt line is high while any pin is pending, enabled and unmasked. A soft-reset register returns the whole channel to its power-on state.

Top module: `gpio_irq_port`

## Requirements
- R1: After reset every register reads 0, `pin_oe` and `pin_out` are 0 and `irq` is low, so all pins are inputs with no interrupts.
- R2: The register at 0x20 holds the direction bits, and a 1 drives the pin (`pin_oe`). The register at 0x18 holds the output latch (`pin_out`). Only the low NPINS bits of each are stored. The unimplemented bits read 0.
- R3: The register at 0x1C returns the pin levels after a two-flop synchronizer. A change on `pin_in` is readable no later than three clock edges later.
- R4: The register at 0x24 holds the trigger codes for pins 0 to 7, and the register at 0x28 holds those for pins 8 to 15. Each code is 3 bits wide and starts at bit 4 times the pin's position within its word. Bit 3 of each nibble reads 0, and so do the fields of pins that do not exist.
- R5: Code 0 triggers on a falling edge, code 1 on a rising edge and code 4 on either edge. The edge is found by comparing the synchronized value with its value one cycle earlier. The status bit at 0x04 then stays set until it is cleared.
- R6: Code 2 triggers on a low level and code 3 on a high level. Status is set on every cycle the level holds, so a clear while the level persists is overridden at once.
- R7: The enable register at 0x00 is read/write. A pin whose enable bit is 0 never sets its status bit.
- R8: Writing a 1 to a bit at 0x0C clears that pin's status. A 0 bit has no effect.
- R9: Writing ones to 0x10 masks those pins, and writing ones to 0x14 unmasks them. The mask reads back at 0x10, and 0x14 reads 0. The register at 0x08 reads status AND enable AND NOT mask, and `irq` is the OR of those bits.
- R10: Trigger codes 5, 6 and 7 never set status.
- R11: Writing 1 to bit 0 of 0x30 holds the channel in reset, and 0x30 reads back 1. Writing 0 afterwards leaves every other register at 0.
- R12: Address 0x2C and addresses above 0x30 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 6 | Byte address; the low two bits are ignored |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid the cycle after `rd_en` |
| pin_in | input | NPINS | Asynchronous pin levels |
| pin_out | output | NPINS | Output latch |
| pin_oe | output | NPINS | Drive enable per pin |
| irq | output | 1 | Interrupt request |

## Verification
The bench goes after the interaction between a level trigger and a clear. If the clear were given priority over a persisting level, a level-mode pin would read 0 after the clear instead of staying set. It also sets several pins to different modes and moves them together. Each mode then has to record only its own edge, and a wrong mode decode or a wrong field position in the mode words would show up as a wrong status pattern. Further checks exercise the remaining behaviours:
- A clear write carrying zeros must change nothing.
- Codes 5 to 7 must never set status.
- A disabled pin must stay silent while its level toggles.
- Partial masking must drop exactly the masked pins from the display register and from `irq`.
- A soft reset must clear the direction and output latches as well as the interrupt state.

Random write and readback of the plain registers catches a design that stores bits which do not exist.

// File: rtl/gpio_irq_port.sv
module gpio_irq_port #(
  parameter int NPINS = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [5:0]       bus_addr,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [31:0]      wdata,
  output logic [31:0]      rdata,
  input  logic [NPINS-1:0] pin_in,
  output logic [NPINS-1:0] pin_out,
  output logic [NPINS-1:0] pin_oe,
  output logic             irq
);
  localparam logic [3:0] W_IEN  = 4'd0;
  localparam logic [3:0] W_STAT = 4'd1;
  localparam logic [3:0] W_DISP = 4'd2;
  localparam logic [3:0] W_CLR  = 4'd3;
  localparam logic [3:0] W_MSET = 4'd4;
  localparam logic [3:0] W_MCLR = 4'd5;
  localparam logic [3:0] W_OUT  = 4'd6;
  localparam logic [3:0] W_IN   = 4'd7;
  localparam logic [3:0] W_DIR  = 4'd8;
  localparam logic [3:0] W_MOD0 = 4'd9;
  localparam logic [3:0] W_MOD1 = 4'd10;
  localparam logic [3:0] W_SRST = 4'd12;

  logic [3:0] word;
  assign word = bus_addr[5:2];

  logic             srst_q;
  logic [NPINS-1:0] ien, status, mask, po, pm;
  logic [NPINS-1:0] sync1, sync2, prev;
  logic [2:0]       mode [NPINS];
  logic [NPINS-1:0] hit, disp;
  logic [31:0]      mode_w0, mode_w1, rd_mux;

  logic wr_ok;
  assign wr_ok = wr_en && !srst_q;

  logic unused_bits;
  assign unused_bits = ^{bus_addr[1:0], wdata};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) srst_q <= 1'b0;
    else if (wr_en && word == W_SRST) srst_q <= wdata[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1 <= '0;
      sync2 <= '0;
      prev  <= '0;
    end else if (srst_q) begin
      sync1 <= '0;
      sync2 <= '0;
      prev  <= '0;
    end else begin
      sync1 <= pin_in;
      sync2 <= sync1;
      prev  <= sync2;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ien <= '0;
      po  <= '0;
      pm  <= '0;
    end else if (srst_q) begin
      ien <= '0;
      po  <= '0;
      pm  <= '0;
    end else if (wr_ok) begin
      if (word == W_IEN) ien <= wdata[NPINS-1:0];
      if (word == W_OUT) po  <= wdata[NPINS-1:0];
      if (word == W_DIR) pm  <= wdata[NPINS-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask <= '0;
    else if (srst_q) mask <= '0;
    else if (wr_ok && word == W_MSET) mask <= mask | wdata[NPINS-1:0];
    else if (wr_ok && word == W_MCLR) mask <= mask & ~wdata[NPINS-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NPINS; i++) mode[i] <= 3'd0;
    end else if (srst_q) begin
      for (int i = 0; i < NPINS; i++) mode[i] <= 3'd0;
    end else if (wr_ok) begin
      for (int i = 0; i < NPINS; i++) begin
        if (i < 8 && word == W_MOD0) mode[i] <= wdata[4*(i%8) +: 3];
        if (i >= 8 && word == W_MOD1) mode[i] <= wdata[4*(i%8) +: 3];
      end
    end
  end

  for (genvar g = 0; g < NPINS; g++) begin : g_det
    always_comb begin
      case (mode[g])
        3'd0:    hit[g] = prev[g] & ~sync2[g];
        3'd1:    hit[g] = ~prev[g] & sync2[g];
        3'd2:    hit[g] = ~sync2[g];
        3'd3:    hit[g] = sync2[g];
        3'd4:    hit[g] = prev[g] ^ sync2[g];
        default: hit[g] = 1'b0;
      endcase
    end
  end

  logic [NPINS-1:0] clr_bits;
  assign clr_bits = (wr_ok && word == W_CLR) ? wdata[NPINS-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status <= '0;
    else if (srst_q) status <= '0;
    else status <= (status & ~clr_bits) | (hit & ien);
  end

  assign disp    = status & ien & ~mask;
  assign irq     = |disp;
  assign pin_out = po;
  assign pin_oe  = pm;

  always_comb begin
    mode_w0 = '0;
    mode_w1 = '0;
    for (int i = 0; i < NPINS; i++) begin
      if (i < 8) mode_w0[4*(i%8) +: 3] = mode[i];
      else       mode_w1[4*(i%8) +: 3] = mode[i];
    end
  end

  always_comb begin
    rd_mux = '0;
    case (word)
      W_IEN:   rd_mux[NPINS-1:0] = ien;
      W_STAT:  rd_mux[NPINS-1:0] = status;
      W_DISP:  rd_mux[NPINS-1:0] = disp;
      W_MSET:  rd_mux[NPINS-1:0] = mask;
      W_OUT:   rd_mux[NPINS-1:0] = po;
      W_IN:    rd_mux[NPINS-1:0] = sync2;
      W_DIR:   rd_mux[NPINS-1:0] = pm;
      W_MOD0:  rd_mux = mode_w0;
      W_MOD1:  rd_mux = mode_w1;
      W_SRST:  rd_mux[0] = srst_q;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
  end
endmodule

// File: rtl/gpio_irq_port_chk.sv
module gpio_irq_port_chk #(
  parameter int NPINS = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [5:0]       bus_addr,
  input logic             wr_en,
  input logic             rd_en,
  input logic [31:0]      wdata,
  input logic [31:0]      rdata,
  input logic [NPINS-1:0] pin_out,
  input logic [NPINS-1:0] pin_oe,
  input logic             irq,
  input logic             srst
);
  // R2
  dir_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && bus_addr[5:2] == 4'd8 && !srst) |=> pin_oe == $past(wdata[NPINS-1:0]));

  // R2
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(wr_en && bus_addr[5:2] == 4'd6) && !srst) |=> $stable(pin_out));

  // R9
  mask_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && bus_addr[5:2] == 4'd4 && (&wdata[NPINS-1:0]) && !srst) |=> !irq);

  // R11
  soft_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    srst |=> (pin_oe == '0 && pin_out == '0 && !irq));

  // R2
  upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && bus_addr[5:2] <= 4'd8) |=> rdata[31:NPINS] == '0);
endmodule

bind gpio_irq_port gpio_irq_port_chk #(.NPINS(NPINS)) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .wr_en(wr_en), .rd_en(rd_en),
  .wdata(wdata), .rdata(rdata), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq),
  .srst(srst_q)
);

// File: tb/gpio_irq_port_test.sv
module gpio_irq_port_test;
  localparam int NPINS = 16;
  localparam time PERIOD = 10ns;

  logic clk = 0, rst_n = 0, wr_en = 0, rd_en = 0;
  logic [5:0] bus_addr = 0;
  logic [31:0] wdata = 0, rdata;
  logic [NPINS-1:0] pin_in = 0, pin_out, pin_oe;
  logic irq;
  int tests = 0, fails = 0;
  bit done = 0;

  gpio_irq_port #(.NPINS(NPINS)) uut (.*);

  always #(PERIOD/2) clk = ~clk;

  function automatic logic [31:0] pin_mask();
    return (32'd1 << NPINS) - 1;
  endfunction

  function automatic logic [31:0] mode_mask(input int base);
    logic [31:0] m = '0;
    for (int i = 0; i < 8; i++) if (base + i < NPINS) m[4*i +: 3] = 3'b111;
    return m;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; wdata = d; wr_en = 1;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; rd_en = 1;
    @(negedge clk);
    rd_en = 0;
    d = rdata;
  endtask

  task automatic rd_chk(input string req, input logic [5:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    check(req, d, exp);
  endtask

  task automatic drive(input logic [NPINS-1:0] v);
    @(negedge clk);
    pin_in = v;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #(PERIOD * 150000);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, m0;
    logic [5:0] a;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    for (int w = 0; w <= 10; w++) rd_chk("R1", 6'(w*4), 0);
    @(negedge clk);
    check("R1 irq", {31'd0, irq}, 0);
    check("R1 oe", {16'd0, pin_oe}, 0);

    // R2 R4 random register readback
    for (int k = 0; k < 40; k++) begin
      case ($urandom_range(0, 4))
        0: a = 6'h00; 1: a = 6'h18; 2: a = 6'h20; 3: a = 6'h24; default: a = 6'h28;
      endcase
      d = $urandom;
      wr(a, d);
      if (a == 6'h24)      rd_chk("R4 mode0", a, d & mode_mask(0));
      else if (a == 6'h28) rd_chk("R4 mode1", a, d & mode_mask(8));
      else                 rd_chk("R2 rw", a, d & pin_mask());
      if (a == 6'h18) check("R2 pin_out", {16'd0, pin_out}, d & pin_mask());
      if (a == 6'h20) check("R2 pin_oe", {16'd0, pin_oe}, d & pin_mask());
    end
    wr(6'h00, 0); wr(6'h18, 0); wr(6'h20, 0); wr(6'h28, 0); wr(6'h0C, 32'hFFFF);

    // R3 synchronized input
    for (int k = 0; k < 6; k++) begin
      d = $urandom & pin_mask();
      drive(d[NPINS-1:0]);
      rd_chk("R3 input", 6'h1C, d);
    end
    drive('0);

    // Modes: p0 fall, p1 rise, p2 low, p3 high, p4 both, p5 code5, p6 code7
    m0 = (0 << 0) | (1 << 4) | (2 << 8) | (3 << 12) | (4 << 16) | (5 << 20) | (7 << 24);
    wr(6'h24, m0);
    wr(6'h00, 32'h7F);
    wr(6'h0C, 32'hFFFF);
    rd_chk("R6 low persists after clear", 6'h04, 32'h04);
    drive(16'h007F);
    rd_chk("R5 rise/both/high", 6'h04, 32'h1E);
    wr(6'h0C, 32'hFFFF);
    rd_chk("R6 high re-sets, R5 edges cleared", 6'h04, 32'h08);
    drive(16'h0000);
    rd_chk("R5 fall/both, R10 codes 5 and 7 silent", 6'h04, 32'h1D);
    wr(6'h0C, 32'h0);
    rd_chk("R8 zero clear no effect", 6'h04, 32'h1D);
    wr(6'h0C, 32'h1);
    rd_chk("R8 single clear", 6'h04, 32'h1C);

    // R7 disabled pins
    wr(6'h00, 0);
    wr(6'h0C, 32'hFFFF);
    drive(16'h007F);
    drive(16'h0000);
    rd_chk("R7 disabled silent", 6'h04, 0);
    check("R7 irq", {31'd0, irq}, 0);

    // R9 masking
    wr(6'h00, 32'h1F);
    drive(16'h007F);
    drive(16'h0000);
    rd_chk("R9 status", 6'h04, 32'h1F);
    rd_chk("R9 display", 6'h08, 32'h1F);
    check("R9 irq on", {31'd0, irq}, 1);
    wr(6'h10, 32'h1B);
    rd_chk("R9 display partial", 6'h08, 32'h04);
    rd_chk("R9 mask read", 6'h10, 32'h1B);
    check("R9 irq partial", {31'd0, irq}, 1);
    wr(6'h10, 32'h04);
    rd_chk("R9 display none", 6'h08, 0);
    @(negedge clk);
    check("R9 irq off", {31'd0, irq}, 0);
    wr(6'h14, 32'h01);
    rd_chk("R9 display unmask", 6'h08, 32'h01);
    rd_chk("R9 mask after clr", 6'h10, 32'h1E);
    rd_chk("R9 clr reads zero", 6'h14, 0);
    check("R9 irq back", {31'd0, irq}, 1);

    // R11 soft reset
    wr(6'h20, 32'hAAAA);
    wr(6'h18, 32'h5555);
    wr(6'h30, 1);
    rd_chk("R11 srst reads 1", 6'h30, 1);
    wr(6'h30, 0);
    for (int w = 0; w <= 10; w++) rd_chk("R11 cleared", 6'(w*4), 0);
    check("R11 oe", {16'd0, pin_oe}, 0);
    check("R11 out", {16'd0, pin_out}, 0);
    check("R11 irq", {31'd0, irq}, 0);

    // R12 unmapped
    rd_chk("R12 0x2C", 6'h2C, 0);
    rd_chk("R12 0x34", 6'h34, 0);
    rd_chk("R12 0x3C", 6'h3C, 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule